// File: doc/BRIEF.md
# Debounced Manual Reset Detector

This block watches a push-button style manual-reset level and decides whether it is a genuine reset request or noise. The level is first brought into the clock domain through a two-flop synchroniser and is then looked at only on the cycles where a slow tick enable is high (one tick stands for about 10 ms of the timer's low-frequency oscillator). A request is accepted only after a run of consecutive high samples. While it is accepted, the block clears the timer's counters and forces both the reset output and the wake output of the surrounding timer low. After the button is let go, the reset is held for a debounce span plus a full reset-pulse span before the counters may run again.

The control is a five-state machine. IDLE waits for a high sample and moves to QUALIFY. QUALIFY returns to IDLE on any low sample, and moves to ACTIVE once `QUAL_TICKS` consecutive high samples have been seen. ACTIVE stays put while samples are high and moves to DEBOUNCE on the first low sample. DEBOUNCE goes back to ACTIVE on a high sample, and on to RESET_HOLD after `DB_TICKS` low ticks. RESET_HOLD ignores the input, counts `HOLD_TICKS` ticks and then returns to IDLE. A single shared tick counter is cleared on every state change.

Top module: `mrst_debounce`

## Requirements
- R1: With `rst_n` low the block is in IDLE and `cnt_clr`, `rstn_low_req` and `wake_low_req` are all 0 (an active-high request value of 1 means "force").
- R2: Outputs stay 0 until `QUAL_TICKS` (default 2) consecutive tick samples read high; a low tick sample before that returns the block to IDLE with outputs still 0.
- R3: `mr_raw` passes through two synchroniser flops, and a high pulse that does not reach a tick sample has no effect on any output.
- R4: The outputs go to 1 on the clock edge of the tick whose sample completes qualification.
- R5: Once asserted, the outputs stay 1 for as long as tick samples keep reading high.
- R6: After the first low tick sample (the release tick), the outputs stay 1 and return to 0 on exactly the `DB_TICKS + HOLD_TICKS`-th tick after the release tick (defaults 2 and 32, so the 34th).
- R7: A high tick sample during the debounce span returns the block to the held state, and the debounce span restarts from the next low sample.
- R8: During the reset-hold span the input is ignored: high samples there neither extend nor shorten the hold, and the block ends in IDLE with outputs 0.
- R9: Outputs change only on a clock edge at which `tick_en` is high.
- R10: `cnt_clr`, `rstn_low_req` and `wake_low_req` are always equal to one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable marking a slow-oscillator tick |
| mr_raw | input | 1 | Raw, asynchronous manual-reset level |
| cnt_clr | output | 1 | Holds the timer's counters cleared when 1 |
| rstn_low_req | output | 1 | Forces the timer's reset output low when 1 |
| wake_low_req | output | 1 | Forces the timer's wake output low when 1 |

## Verification
A state or counter fault shows at the ports as the request outputs going high one tick too early or too late, or dropping at the wrong tick after release; every such fault is visible on the tick edge where the wrong transition happens, since the outputs are decoded straight from the state. A stuck synchroniser or a wrong qualification count shows within two ticks of the first high sample. The debounce and hold counts are checked by counting ticks from the release sample to the falling edge of the outputs, including runs with a bounce during debounce and a press during the hold.

// File: rtl/mrst_pkg.sv
package mrst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_QUALIFY    = 3'd1,
        ST_ACTIVE     = 3'd2,
        ST_DEBOUNCE   = 3'd3,
        ST_RESET_HOLD = 3'd4
    } mrst_state_e;

endpackage

// File: rtl/mrst_sync.sv
module mrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/mrst_tick_cnt.sv
module mrst_tick_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          count <= '0;
        else if (restart)                    count <= '0;
        else if (step && count != CNT_MAX)   count <= count + 1'b1;
    end
endmodule

// File: rtl/mrst_fsm.sv
module mrst_fsm
    import mrst_pkg::*;
#(
    parameter int QUAL_TICKS = 2,
    parameter int DB_TICKS   = 2,
    parameter int HOLD_TICKS = 32,
    parameter int CNT_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             level,
    input  logic [CNT_W-1:0] count,
    output logic             cnt_restart,
    output logic             cnt_step,
    output logic             clr_o,
    output logic             rstn_low_o,
    output logic             wake_low_o
);
    localparam int QUAL_LAST = QUAL_TICKS - 2;
    localparam int DB_LAST   = DB_TICKS - 1;
    localparam int HOLD_LAST = HOLD_TICKS - 1;

    mrst_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tick && level) state_d = ST_QUALIFY;
            end
            ST_QUALIFY: begin
                if (tick) begin
                    if (!level)                       state_d = ST_IDLE;
                    else if (int'(count) == QUAL_LAST) state_d = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (tick && !level) state_d = ST_DEBOUNCE;
            end
            ST_DEBOUNCE: begin
                if (tick) begin
                    if (level)                       state_d = ST_ACTIVE;
                    else if (int'(count) == DB_LAST) state_d = ST_RESET_HOLD;
                end
            end
            ST_RESET_HOLD: begin
                if (tick && int'(count) == HOLD_LAST) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cnt_restart = (state_d != state_q);
    assign cnt_step    = tick && (state_d == state_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        clr_o      = 1'b0;
        rstn_low_o = 1'b0;
        wake_low_o = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_QUALIFY: begin
                clr_o      = 1'b0;
                rstn_low_o = 1'b0;
                wake_low_o = 1'b0;
            end
            ST_ACTIVE, ST_DEBOUNCE, ST_RESET_HOLD: begin
                clr_o      = 1'b1;
                rstn_low_o = 1'b1;
                wake_low_o = 1'b1;
            end
            default: begin
                clr_o      = 1'b1;
                rstn_low_o = 1'b1;
                wake_low_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/mrst_debounce.sv
module mrst_debounce #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_TICKS  = 2,
    parameter int DB_TICKS    = 2,
    parameter int HOLD_TICKS  = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic mr_raw,
    output logic cnt_clr,
    output logic rstn_low_req,
    output logic wake_low_req
);
    localparam int MAX_SPAN = (HOLD_TICKS > DB_TICKS)
                            ? ((HOLD_TICKS > QUAL_TICKS) ? HOLD_TICKS : QUAL_TICKS)
                            : ((DB_TICKS > QUAL_TICKS) ? DB_TICKS : QUAL_TICKS);
    localparam int CNT_W = $clog2(MAX_SPAN + 1);

    logic             mr_sync;
    logic             cnt_restart;
    logic             cnt_step;
    logic [CNT_W-1:0] tick_count;

    mrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (mr_raw),
        .d_out (mr_sync)
    );

    mrst_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cnt_restart),
        .step    (cnt_step),
        .count   (tick_count)
    );

    mrst_fsm #(
        .QUAL_TICKS (QUAL_TICKS),
        .DB_TICKS   (DB_TICKS),
        .HOLD_TICKS (HOLD_TICKS),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick_en),
        .level       (mr_sync),
        .count       (tick_count),
        .cnt_restart (cnt_restart),
        .cnt_step    (cnt_step),
        .clr_o       (cnt_clr),
        .rstn_low_o  (rstn_low_req),
        .wake_low_o  (wake_low_req)
    );
endmodule

// File: rtl/mrst_debounce_chk.sv
module mrst_debounce_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_en,
    input logic mr_s,
    input logic cnt_clr,
    input logic rstn_low_req,
    input logic wake_low_req
);
    AST_OUTS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr == rstn_low_req) && (wake_low_req == rstn_low_req)); // R10

    AST_STABLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_en) |-> $stable(rstn_low_req)); // R9

    AST_RISE_ON_HIGH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rstn_low_req) |-> ($past(tick_en) && $past(mr_s))); // R4

    AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rstn_low_req) |-> $past(tick_en)); // R6
endmodule

bind mrst_debounce mrst_debounce_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .mr_s         (mr_sync),
    .cnt_clr      (cnt_clr),
    .rstn_low_req (rstn_low_req),
    .wake_low_req (wake_low_req)
);

// File: tb/mrst_debounce_bench.sv
module mrst_debounce_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic mr_raw = 1'b0;
    logic cnt_clr, rstn_low_req, wake_low_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    mrst_debounce u_mrst_debounce (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .mr_raw       (mr_raw),
        .cnt_clr      (cnt_clr),
        .rstn_low_req (rstn_low_req),
        .wake_low_req (wake_low_req)
    );

    task automatic check_now(bit exp, string tag);
        n_cmp++;
        if (cnt_clr !== exp || rstn_low_req !== exp || wake_low_req !== exp) begin
            n_bad++;
            $display("FAIL %s: clr=%b rstn_low=%b wake_low=%b expected %b",
                     tag, cnt_clr, rstn_low_req, wake_low_req, exp);
        end
    endtask

    // driver: set level, let it cross the synchroniser, then one tick
    task automatic step(bit lvl, bit exp, string tag);
        @(negedge clk);
        mr_raw = lvl;
        repeat (3) @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    // monitor: compare one cycle after each tick edge
    initial begin
        forever begin
            @(posedge clk);
            if (tick_en) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL scoreboard: tick with no expected item, actual %b expected none", rstn_low_req);
                end else begin
                    check_now(exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung, actual running expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_now(1'b0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: lone high sample is rejected
        step(1'b1, 1'b0, "R2 first high");
        step(1'b0, 1'b0, "R2 low aborts");
        step(1'b0, 1'b0, "R2 idle");

        // R3: one-clock glitch between ticks
        @(negedge clk); mr_raw = 1'b1;
        @(negedge clk); mr_raw = 1'b0;
        repeat (4) @(negedge clk);
        step(1'b0, 1'b0, "R3 glitch ignored");
        step(1'b0, 1'b0, "R3 glitch ignored 2");

        // R4/R5: valid press
        step(1'b1, 1'b0, "R2 qualify");
        step(1'b1, 1'b1, "R4 asserted");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R5 held");

        // R6: release, DB+HOLD ticks
        for (int i = 0; i < 34; i++) step(1'b0, 1'b1, "R6 stretched");
        step(1'b0, 1'b0, "R6 released");
        step(1'b0, 1'b0, "R6 idle");

        // R7/R8: bounce in debounce, press during hold
        step(1'b1, 1'b0, "R2 qualify again");
        step(1'b1, 1'b1, "R4 asserted again");
        step(1'b0, 1'b1, "R7 release");
        step(1'b1, 1'b1, "R7 bounce");
        step(1'b0, 1'b1, "R7 release again");
        step(1'b0, 1'b1, "R7 debounce");
        step(1'b0, 1'b1, "R7 into hold");
        for (int i = 0; i < 3; i++)  step(1'b1, 1'b1, "R8 press ignored");
        for (int i = 0; i < 28; i++) step(1'b0, 1'b1, "R8 hold");
        step(1'b0, 1'b0, "R8 hold ends");
        step(1'b0, 1'b0, "R8 idle");

        // R1: reset while asserted
        step(1'b1, 1'b0, "R2 qualify 3");
        step(1'b1, 1'b1, "R4 asserted 3");
        @(negedge clk); rst_n = 1'b0; mr_raw = 1'b0;
        @(negedge clk);
        check_now(1'b0, "R1 reset mid-press");
        rst_n = 1'b1;
        step(1'b0, 1'b0, "R1 idle after reset");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        summary();
    end
endmodule